// File: doc/BRIEF.md
# Port Pin Control and Event Detection

This block holds one control word per pin for a 32-pin port. Each word selects the pin's function, sets its pull resistor, and sets a 4-bit trigger code that decides how the pin raises events. The function field and the pull bits are only stored and driven out to the pad and routing logic, which lie outside this block.

Each pin input passes through a two-flop synchroniser. The synchronised value is then compared with its value on the previous cycle. Depending on its trigger code, a pin can raise an event on a rising edge, a falling edge, either edge, or while the pin is held at zero or held at one. An event sets a sticky per-pin flag. The trigger code also routes the flag: a combined interrupt request gathers the flags of pins with interrupt codes, and a combined DMA request gathers the flags of pins with DMA codes. Software reaches all of this through a word-wide register bus with an address, a write enable, write data and combinational read data.

The block has no sequencer. Pipeline stages hold all of its state: the synchroniser, the previous-value register and the flag register. It has no enumerated control states.

Top module: `pinctl_port`

## Requirements
- R1: The control word of pin n is at byte address 4*n (0x00 to 0x7C). Only bits 19:16 (trigger code), 10:8 (function) and 1:0 (pull) are stored. Every other bit reads as zero and ignores writes, so writing 0xFFFFFFFF reads back as 0x000F0703.
- R2: `mux_sel_o[3n+2:3n]` carries bits 10:8 of pin n's word. `pull_en_o[n]` carries bit 1, and `pull_up_o[n]` carries bit 0 (1 selects up, 0 selects down).
- R3: Trigger code 0001 sets pin n's flag on a rising edge of the pin and routes it to `dma_o`. A falling edge does not set the flag.
- R4: Trigger code 0010 sets the flag on a falling edge, and code 0011 sets it on either edge. Both codes route the flag to `dma_o`, and neither affects `irq_o`.
- R5: Trigger codes 1001, 1010 and 1011 set the flag on a rising, a falling or either edge, and route it to `irq_o`.
- R6: Trigger code 1000 sets the flag on every cycle the synchronised pin is 0, and code 1100 on every cycle it is 1. Both route the flag to `irq_o`. A level flag that is cleared while the level persists reads 0 right after the clearing write and 1 one cycle later.
- R7: Trigger code 0000 and the reserved codes (0100 to 0111, 1101 to 1111) never set a flag.
- R8: The flag word is at byte address 0xA0, with bit n belonging to pin n. Writing 1 to a bit clears that flag, and writing 0 leaves it unchanged. A clear takes priority over an event in the same cycle.
- R9: A pin change driven before clock edge k reaches the synchroniser at edge k and its second stage at edge k+1. The flag is set at edge k+2, and not earlier.
- R10: `irq_o` is the OR of the flags whose pin currently holds an interrupt code, and `dma_o` the OR of those whose pin holds a DMA code. If the code changes, the routing changes at once, and the flag itself stays set.
- R11: After reset, all control words and flags are zero, and `irq_o` and `dma_o` are low.
- R12: Addresses outside the control words and the flag word read as zero, and writes to them change no state. This includes addresses that are not word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Asynchronous pin inputs |
| mux_sel_o | output | 96 | Function select, 3 bits per pin |
| pull_en_o | output | 32 | Pull resistor enable per pin |
| pull_up_o | output | 32 | Pull direction per pin, 1 = up |
| irq_o | output | 1 | Combined interrupt request |
| dma_o | output | 1 | Combined DMA request |

## Verification
The table-driven part applies each trigger code to an edge or level of its own choosing, and expects the flag and exactly one of the two requests. A decoder that confuses the edge polarity, or that routes a code to the wrong request, shows up as a wrong flag or a wrong request line. The directed tests target these faults:
- **Latency:** the flag must still be clear two edges after a pin change and set on the third. A missing or extra synchroniser stage therefore fails.
- **Level re-arm:** a clear issued while the level persists must read 0 first and then 1. A design that lets the event win over the clear, or that makes level flags edge-like, fails.
- **Routing after a code change:** changing the code must move or drop the request while the flag stays set.
- **Register masking and decoding:** reserved bits, unmapped addresses and misaligned addresses must read as zero and ignore writes.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    // Bits of a control word that hold state
    localparam logic [31:0] CTL_KEEP = 32'h000F_0703;

    typedef enum logic [3:0] {
        TRG_OFF      = 4'b0000,
        TRG_DMA_RISE = 4'b0001,
        TRG_DMA_FALL = 4'b0010,
        TRG_DMA_BOTH = 4'b0011,
        TRG_IRQ_LOW  = 4'b1000,
        TRG_IRQ_RISE = 4'b1001,
        TRG_IRQ_FALL = 4'b1010,
        TRG_IRQ_BOTH = 4'b1011,
        TRG_IRQ_HIGH = 4'b1100
    } trig_e;

    typedef struct packed {
        logic to_irq;
        logic to_dma;
        logic on_rise;
        logic on_fall;
        logic on_low;
        logic on_high;
    } sense_t;

    function automatic sense_t decode_trig(input logic [3:0] code);
        sense_t s;
        s = '0;
        case (code)
            TRG_DMA_RISE: begin s.to_dma = 1'b1; s.on_rise = 1'b1; end
            TRG_DMA_FALL: begin s.to_dma = 1'b1; s.on_fall = 1'b1; end
            TRG_DMA_BOTH: begin s.to_dma = 1'b1; s.on_rise = 1'b1; s.on_fall = 1'b1; end
            TRG_IRQ_LOW:  begin s.to_irq = 1'b1; s.on_low  = 1'b1; end
            TRG_IRQ_RISE: begin s.to_irq = 1'b1; s.on_rise = 1'b1; end
            TRG_IRQ_FALL: begin s.to_irq = 1'b1; s.on_fall = 1'b1; end
            TRG_IRQ_BOTH: begin s.to_irq = 1'b1; s.on_rise = 1'b1; s.on_fall = 1'b1; end
            TRG_IRQ_HIGH: begin s.to_irq = 1'b1; s.on_high = 1'b1; end
            default:      s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] now_q,
    output logic [WIDTH-1:0] last_q
);
    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            now_q  <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw_in;
            now_q  <= meta_q;
            last_q <= now_q;
        end
    end
endmodule

// File: rtl/pinctl_sense.sv
module pinctl_sense
    import pinctl_pkg::*;
#(
    parameter int N_PINS = 32
) (
    input  logic [N_PINS*4-1:0] trig_codes,
    input  logic [N_PINS-1:0]   now_lvl,
    input  logic [N_PINS-1:0]   last_lvl,
    output logic [N_PINS-1:0]   evt,
    output logic [N_PINS-1:0]   irq_route,
    output logic [N_PINS-1:0]   dma_route
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        sense_t s;
        always_comb begin
            s            = decode_trig(trig_codes[p*4 +: 4]);
            irq_route[p] = s.to_irq;
            dma_route[p] = s.to_dma;
            evt[p]       = (s.on_rise &  now_lvl[p] & ~last_lvl[p])
                         | (s.on_fall & ~now_lvl[p] &  last_lvl[p])
                         | (s.on_low  & ~now_lvl[p])
                         | (s.on_high &  now_lvl[p]);
        end
    end
endmodule

// File: rtl/pinctl_port.sv
module pinctl_port
    import pinctl_pkg::*;
#(
    parameter int          N_PINS    = 32,
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  FLAG_ADDR = 8'hA0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [N_PINS-1:0]   pad_in,
    output logic [N_PINS*3-1:0] mux_sel_o,
    output logic [N_PINS-1:0]   pull_en_o,
    output logic [N_PINS-1:0]   pull_up_o,
    output logic                irq_o,
    output logic                dma_o
);
    localparam int IDX_W   = $clog2(N_PINS);
    localparam int CTL_END = N_PINS * 4;

    logic [N_PINS*4-1:0] trig_q;
    logic [N_PINS-1:0]   now_lvl, last_lvl, evt, irq_route, dma_route;
    logic [N_PINS-1:0]   flags, clr_mask;
    logic                ctl_hit, flag_hit;
    logic [IDX_W-1:0]    idx;

    assign idx      = bus_addr[IDX_W+1:2];
    assign ctl_hit  = (bus_addr[1:0] == 2'b00) && (int'(bus_addr) < CTL_END);
    assign flag_hit = (bus_addr == ADDR_W'(FLAG_ADDR));
    assign clr_mask = (bus_we && flag_hit) ? bus_wdata[N_PINS-1:0] : '0;

    logic unused_wbits;
    assign unused_wbits = ^{bus_wdata[31:20], bus_wdata[15:11], bus_wdata[7:2]};

    // Per-pin control words
    for (genvar p = 0; p < N_PINS; p++) begin : g_ctl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trig_q[p*4 +: 4]    <= '0;
                mux_sel_o[p*3 +: 3] <= '0;
                pull_en_o[p]        <= 1'b0;
                pull_up_o[p]        <= 1'b0;
            end else if (bus_we && ctl_hit && idx == IDX_W'(p)) begin
                trig_q[p*4 +: 4]    <= bus_wdata[19:16];
                mux_sel_o[p*3 +: 3] <= bus_wdata[10:8];
                pull_en_o[p]        <= bus_wdata[1];
                pull_up_o[p]        <= bus_wdata[0];
            end
        end
    end

    pinctl_sync #(.WIDTH(N_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (pad_in),
        .now_q  (now_lvl),
        .last_q (last_lvl)
    );

    pinctl_sense #(.N_PINS(N_PINS)) u_sense (
        .trig_codes (trig_q),
        .now_lvl    (now_lvl),
        .last_lvl   (last_lvl),
        .evt        (evt),
        .irq_route  (irq_route),
        .dma_route  (dma_route)
    );

    // Sticky flags: clear wins over a same-cycle event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags | evt) & ~clr_mask;
    end

    assign irq_o = |(flags & irq_route);
    assign dma_o = |(flags & dma_route);

    always_comb begin
        bus_rdata = '0;
        if (ctl_hit) begin
            bus_rdata[19:16] = trig_q[idx*4 +: 4];
            bus_rdata[10:8]  = mux_sel_o[idx*3 +: 3];
            bus_rdata[1]     = pull_en_o[idx];
            bus_rdata[0]     = pull_up_o[idx];
        end else if (flag_hit) begin
            bus_rdata[N_PINS-1:0] = flags;
        end
    end
endmodule

// File: rtl/pinctl_port_chk.sv
module pinctl_port_chk
    import pinctl_pkg::*;
#(
    parameter int         N_PINS    = 32,
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] FLAG_ADDR = 8'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [N_PINS-1:0] flags,
    input logic [N_PINS-1:0] evt,
    input logic              irq_o,
    input logic              dma_o
);
    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (flags != '0));  // R10
    AST_DMA_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dma_o |-> (flags != '0));  // R10
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(FLAG_ADDR)) |=> ((flags & $past(bus_wdata[N_PINS-1:0])) == '0));  // R8
    AST_SET_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~$past(flags) & ~$past(evt)) == '0));  // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bus_addr) < N_PINS*4) |-> ((bus_rdata & ~CTL_KEEP) == '0));  // R1
endmodule

bind pinctl_port pinctl_port_chk #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags), .evt(evt),
    .irq_o(irq_o), .dma_o(dma_o)
);

// File: tb/pinctl_port_bench.sv
`timescale 1ns/1ps
module pinctl_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [95:0] mux_sel_o;
    logic [31:0] pull_en_o, pull_up_o;
    logic        irq_o, dma_o;
    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] rd;

    always #4 clk = ~clk;

    pinctl_port u_pinctl_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .mux_sel_o(mux_sel_o), .pull_en_o(pull_en_o), .pull_up_o(pull_up_o),
        .irq_o(irq_o), .dma_o(dma_o)
    );

    // {code, start level, end level, flag, irq, dma, requirement number}
    localparam int NV = 19;
    localparam logic [12:0] VEC [0:NV-1] = '{
        {4'b0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd3},  // R3
        {4'b0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3
        {4'b0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
        {4'b0010, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4
        {4'b0011, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
        {4'b0011, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'd4},  // R4
        {4'b1001, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        {4'b1001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5
        {4'b1010, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        {4'b1011, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        {4'b1011, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
        {4'b1000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
        {4'b1000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6
        {4'b1100, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 4'd6},  // R6
        {4'b0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        {4'b0100, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        {4'b0111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        {4'b1101, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},  // R7
        {4'b1110, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7}   // R7
    };

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        tick();
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();

        // R11 reset state
        rdreg(8'h14, rd);  chk("R11 ctl word", rd, 32'h0);
        rdreg(8'hA0, rd);  chk("R11 flags", rd, 32'h0);
        chk("R11 irq/dma", {30'b0, irq_o, dma_o}, 32'h0);

        // R1 reserved bits masked
        wr(8'h7C, 32'hFFFF_FFFF);
        rdreg(8'h7C, rd);  chk("R1 readback", rd, 32'h000F_0703);
        wr(8'h7C, 32'h0);

        // R2 exports
        wr(8'h0C, 32'h0000_0503);
        chk("R2 func", {29'b0, mux_sel_o[11:9]}, 32'd5);
        chk("R2 pulls", {30'b0, pull_en_o[3], pull_up_o[3]}, 32'd3);
        wr(8'h0C, 32'h0000_0102);
        chk("R2 pull down", {29'b0, mux_sel_o[11:9], pull_en_o[3], pull_up_o[3]}, {27'b0, 3'd1, 2'b10});

        // R12 unmapped and misaligned
        wr(8'h90, 32'hFFFF_FFFF);
        wr(8'h0E, 32'h000F_0000);
        rdreg(8'h90, rd);  chk("R12 unmapped read", rd, 32'h0);
        rdreg(8'h0E, rd);  chk("R12 misaligned read", rd, 32'h0);
        rdreg(8'h0C, rd);  chk("R12 pin3 untouched", rd, 32'h0000_0102);

        // Table walk on pin 5 (R3-R7 tagged per row)
        for (int v = 0; v < NV; v++) begin
            logic [3:0] code;
            code = VEC[v][12:9];
            wr(8'h14, 32'h0);
            pad_in[5] = VEC[v][8];
            tick(4);
            wr(8'h14, {12'b0, code, 16'b0});
            wr(8'hA0, 32'hFFFF_FFFF);
            pad_in[5] = VEC[v][7];
            tick(4);
            rdreg(8'hA0, rd);
            chk($sformatf("R%0d vec %0d flag", VEC[v][3:0], v), {31'b0, rd[5]}, {31'b0, VEC[v][6]});
            chk($sformatf("R%0d vec %0d irq", VEC[v][3:0], v), {31'b0, irq_o}, {31'b0, VEC[v][5]});
            chk($sformatf("R%0d vec %0d dma", VEC[v][3:0], v), {31'b0, dma_o}, {31'b0, VEC[v][4]});
        end
        wr(8'h14, 32'h0);
        pad_in[5] = 1'b0;
        tick(4);
        wr(8'hA0, 32'hFFFF_FFFF);

        // R8 write-one-to-clear, zero has no effect
        wr(8'h20, 32'h0009_0000);          // pin 8 rising edge to interrupt
        pad_in[8] = 1'b1;
        tick(4);
        wr(8'hA0, 32'h0);
        rdreg(8'hA0, rd);  chk("R8 write zero keeps flag", rd, 32'h0000_0100);
        wr(8'hA0, 32'h0000_0100);
        rdreg(8'hA0, rd);  chk("R8 write one clears", rd, 32'h0);
        chk("R8 irq drops", {31'b0, irq_o}, 32'h0);

        // R6 level re-arm after clear
        wr(8'h20, 32'h000C_0000);          // pin 8 high level
        tick();
        wr(8'hA0, 32'h0000_0100);
        rdreg(8'hA0, rd);  chk("R6 cleared this cycle", rd, 32'h0);
        tick();
        rdreg(8'hA0, rd);  chk("R6 sets again", rd, 32'h0000_0100);
        wr(8'h20, 32'h0);
        pad_in[8] = 1'b0;
        tick(4);
        wr(8'hA0, 32'hFFFF_FFFF);

        // R9 latency
        wr(8'h28, 32'h0009_0000);          // pin 10
        pad_in[10] = 1'b1;
        tick(2);
        rdreg(8'hA0, rd);  chk("R9 not yet after two edges", rd, 32'h0);
        tick();
        rdreg(8'hA0, rd);  chk("R9 set on third edge", rd, 32'h0000_0400);

        // R10 routing follows current code
        chk("R10 irq with interrupt code", {30'b0, irq_o, dma_o}, 32'd2);
        wr(8'h28, 32'h0001_0000);
        chk("R10 rerouted to dma", {30'b0, irq_o, dma_o}, 32'd1);
        wr(8'h28, 32'h0);
        chk("R10 off code drops both", {30'b0, irq_o, dma_o}, 32'd0);
        rdreg(8'hA0, rd);  chk("R10 flag kept", rd, 32'h0000_0400);

        finish_up();
    end
endmodule